// File: doc/BRIEF.md
# Control-Read Descriptor Streamer

This block serves the data stage of a control read on endpoint 0 by itself. Software writes a 16-bit start address and a 16-bit byte count into a small byte-wide register file, then sets a start bit together with the IN direction bit. From then on the engine pulls bytes from buffer memory through a combinational read port. It answers each IN token with one packet on a byte stream and waits for the host handshake.

Packets hold at most `MPS` bytes. The read pointer and the remaining count move on only when the host acknowledges a packet, so a timed-out packet goes out again unchanged. The stage ends with the first acknowledged packet shorter than `MPS`. That packet is a zero-length packet when the count is a whole multiple of `MPS`, including a count of zero. When the stage ends, a sticky done flag is raised and the enable bit drops. A freshly received SETUP cancels everything in flight.

Top module: `drep_engine`

## Requirements
- R1: After synchronous reset, `done`, `reply_en`, `tx_valid` and `tx_zlp` are low.
- R2: Register index 1 holds the address low byte, 2 the address high byte, 3 the size low byte and 4 the size high byte. Writing index 0 with bit 0 (enable) and bit 1 (direction IN) both set starts a reply from that address and size, and `reply_en` reads high from the next cycle.
- R3: On an IN token, the packet starts the next cycle with one byte per cycle on `tx_data` under `tx_valid`. It carries min(remaining, MPS) bytes read from consecutive addresses at the current pointer, and `tx_last` marks its final byte.
- R4: The pointer and remaining count advance only on `in_ack`. After `in_timeout`, the next IN token resends the identical packet.
- R5: When the remaining count is zero at an IN token, the engine sends a zero-length packet: `tx_zlp` is high for one cycle and `tx_valid` stays low. This covers both a total size of zero and a size that is an exact multiple of MPS.
- R6: An acknowledged packet shorter than MPS (including a zero-length one) sets `done` and clears `reply_en` at the same clock edge.
- R7: `done` is sticky. Writing index 5 with bit 0 set clears it, and writing 0 there leaves it set.
- R8: Writing index 0 with the enable bit set but the direction bit clear does not start a reply; `reply_en` stays low.
- R9: `setup_rcvd` aborts any reply: `reply_en` clears, `done` is not set, and later tokens are refused.
- R10: An IN token that arrives while the engine is not waiting for one raises `tx_nak` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 8 | Register write data |
| setup_rcvd | input | 1 | SETUP packet received on endpoint 0 |
| in_token | input | 1 | IN token for endpoint 0 |
| in_ack | input | 1 | Host acknowledged the last packet |
| in_timeout | input | 1 | Host handshake missing; packet to be resent |
| mem_addr | output | 16 | Buffer memory read address |
| mem_rdata | input | 8 | Buffer memory read data (same cycle) |
| tx_valid | output | 1 | Packet byte valid |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_zlp | output | 1 | Zero-length packet response |
| tx_nak | output | 1 | Token refused with NAK |
| reply_en | output | 1 | Automatic reply armed |
| done | output | 1 | Sticky stage-complete flag |

## Verification
The assertions check the per-cycle invariants on every cycle. Bytes and zero-length responses appear only while the reply is armed and never together. A rising `done` comes with a cleared `reply_en`. A SETUP always disarms the engine without raising `done`. `done` only falls through a write-one clear, and idle tokens are always refused. Only the bench scenarios can show that packet sizes follow min(remaining, MPS) and that the bytes come from the right addresses. The same holds for the resend after a timeout, the trailing zero-length packet on exact multiples, and the gating on the direction bit.

// File: rtl/drep_pkg.sv
package drep_pkg;

    localparam int DREP_AW = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_TOK,
        ST_SEND,
        ST_WAIT_HS
    } drep_state_e;

    localparam logic [2:0] REG_CTRL    = 3'd0;
    localparam logic [2:0] REG_ADDR_LO = 3'd1;
    localparam logic [2:0] REG_ADDR_HI = 3'd2;
    localparam logic [2:0] REG_SIZE_LO = 3'd3;
    localparam logic [2:0] REG_SIZE_HI = 3'd4;
    localparam logic [2:0] REG_STATUS  = 3'd5;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_DIR_BIT = 1;

    typedef struct packed {
        logic [DREP_AW-1:0] base;
        logic [DREP_AW-1:0] size;
    } drep_window_t;

    function automatic logic [DREP_AW-1:0] drep_min(input logic [DREP_AW-1:0] a,
                                                    input logic [DREP_AW-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/drep_regs.sv
module drep_regs
    import drep_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [7:0]   wr_data,
    input  logic         setup_rcvd,
    input  logic         finish,
    output drep_window_t win,
    output logic         start,
    output logic         reply_en,
    output logic         done
);

    // Start needs both the enable and the IN direction bit in one write.
    always_comb begin
        start = wr_en && (wr_addr == REG_CTRL) && wr_data[CTRL_EN_BIT]
                && wr_data[CTRL_DIR_BIT] && !reply_en && !setup_rcvd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win      <= '0;
            reply_en <= 1'b0;
            done     <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    REG_ADDR_LO: win.base[7:0]  <= wr_data;
                    REG_ADDR_HI: win.base[15:8] <= wr_data;
                    REG_SIZE_LO: win.size[7:0]  <= wr_data;
                    REG_SIZE_HI: win.size[15:8] <= wr_data;
                    default: ;
                endcase
            end
            if (wr_en && (wr_addr == REG_STATUS) && wr_data[0])
                done <= 1'b0;
            if (finish) begin
                done     <= 1'b1;
                reply_en <= 1'b0;
            end
            if (start)
                reply_en <= 1'b1;
            if (setup_rcvd)
                reply_en <= 1'b0;
        end
    end

endmodule

// File: rtl/drep_pktz.sv
module drep_pktz
    import drep_pkg::*;
#(
    parameter int MPS = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               abort,
    input  drep_window_t       win,
    input  logic               in_token,
    input  logic               in_ack,
    input  logic               in_timeout,
    output logic [DREP_AW-1:0] mem_addr,
    input  logic [7:0]         mem_rdata,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    output logic               tx_zlp,
    output logic               tx_nak,
    output logic               finish
);

    localparam logic [DREP_AW-1:0] MPS_W = DREP_AW'(MPS);

    drep_state_e        state;
    logic [DREP_AW-1:0] ptr;
    logic [DREP_AW-1:0] rem;
    logic [DREP_AW-1:0] pkt;
    logic [DREP_AW-1:0] idx;
    logic               pkt_end;

    assign pkt_end = (idx == pkt - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state <= ST_IDLE;
            ptr   <= '0;
            rem   <= '0;
            pkt   <= '0;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    ptr   <= win.base;
                    rem   <= win.size;
                    state <= ST_WAIT_TOK;
                end
                ST_WAIT_TOK: if (in_token) begin
                    pkt   <= drep_min(rem, MPS_W);
                    idx   <= '0;
                    state <= ST_SEND;
                end
                ST_SEND: begin
                    if (pkt == '0 || pkt_end) state <= ST_WAIT_HS;
                    else                      idx   <= idx + 1'b1;
                end
                ST_WAIT_HS: begin
                    if (in_ack) begin
                        ptr   <= ptr + pkt;
                        rem   <= rem - pkt;
                        state <= (pkt < MPS_W) ? ST_IDLE : ST_WAIT_TOK;
                    end else if (in_timeout) begin
                        state <= ST_WAIT_TOK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr = ptr + idx;
        tx_data  = mem_rdata;
        tx_valid = (state == ST_SEND) && (pkt != '0);
        tx_last  = tx_valid && pkt_end;
        tx_zlp   = (state == ST_SEND) && (pkt == '0);
        tx_nak   = in_token && (state != ST_WAIT_TOK);
        finish   = (state == ST_WAIT_HS) && in_ack && (pkt < MPS_W) && !abort;
    end

endmodule

// File: rtl/drep_engine.sv
module drep_engine
    import drep_pkg::*;
#(
    parameter int MPS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        setup_rcvd,
    input  logic        in_token,
    input  logic        in_ack,
    input  logic        in_timeout,
    output logic [15:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    output logic        tx_zlp,
    output logic        tx_nak,
    output logic        reply_en,
    output logic        done
);

    drep_window_t win;
    logic         start;
    logic         finish;

    drep_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .setup_rcvd (setup_rcvd),
        .finish     (finish),
        .win        (win),
        .start      (start),
        .reply_en   (reply_en),
        .done       (done)
    );

    drep_pktz #(.MPS(MPS)) u_pktz (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .abort      (setup_rcvd),
        .win        (win),
        .in_token   (in_token),
        .in_ack     (in_ack),
        .in_timeout (in_timeout),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_zlp     (tx_zlp),
        .tx_nak     (tx_nak),
        .finish     (finish)
    );

endmodule

// File: rtl/drep_engine_chk.sv
module drep_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       setup_rcvd,
    input logic       in_token,
    input logic       tx_valid,
    input logic       tx_zlp,
    input logic       tx_nak,
    input logic       reply_en,
    input logic       done
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!done && !reply_en && !tx_valid && !tx_zlp));

    a_r3_bytes_only_armed: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> reply_en);

    a_r5_zlp_no_bytes: assert property (@(posedge clk) disable iff (rst)
        tx_zlp |-> (!tx_valid && reply_en));

    a_r6_done_disarms: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !reply_en);

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !(wr_en && wr_addr == 3'd5 && wr_data[0])) |=> done);

    a_r9_setup_abort: assert property (@(posedge clk) disable iff (rst)
        (setup_rcvd && !done) |=> (!reply_en && !done && !tx_valid && !tx_zlp));

    a_r10_idle_nak: assert property (@(posedge clk) disable iff (rst)
        (in_token && !reply_en) |-> tx_nak);

endmodule

bind drep_engine drep_engine_chk u_chk (.*);

// File: tb/drep_engine_test.sv
module drep_engine_test;

    localparam int MPS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        setup_rcvd = 1'b0;
    logic        in_token = 1'b0;
    logic        in_ack = 1'b0;
    logic        in_timeout = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        tx_valid, tx_last, tx_zlp, tx_nak, reply_en, done;
    logic [7:0]  tx_data;

    int checks = 0;
    int failures = 0;

    // Reference model state
    int mptr = 0;
    int mrem = 0;
    bit mact = 0;
    bit mdone = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return (a[7:0] * 8'd5) ^ a[15:8] ^ 8'h3C;
    endfunction

    assign mem_rdata = memf(mem_addr);

    drep_engine #(.MPS(MPS)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .setup_rcvd(setup_rcvd), .in_token(in_token), .in_ack(in_ack),
        .in_timeout(in_timeout), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp),
        .tx_nak(tx_nak), .reply_en(reply_en), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    // R2: load window through indices 1..4, then start with enable+direction IN
    task automatic arm(input int base, input int size);
        wreg(3'd1, base[7:0]);
        wreg(3'd2, base[15:8]);
        wreg(3'd3, size[7:0]);
        wreg(3'd4, size[15:8]);
        wreg(3'd0, 8'h03);
        mptr = base; mrem = size; mact = 1;
        check(reply_en == 1'b1, "R2", reply_en, 1);
    endtask

    task automatic do_in(input bit ack);
        int exp_len;
        int got;
        bit zlp;
        @(negedge clk);
        in_token = 1'b1;
        #1;
        if (!mact) begin
            check(tx_nak == 1'b1, "R10", tx_nak, 1);
            @(negedge clk);
            in_token = 1'b0;
            #1;
            return;
        end
        check(tx_nak == 1'b0, "R10", tx_nak, 0);
        @(negedge clk);
        in_token = 1'b0;
        #1;
        exp_len = (mrem < MPS) ? mrem : MPS;
        got = 0;
        zlp = 0;
        for (int k = 0; k < MPS + 2; k++) begin
            if (tx_zlp) begin
                zlp = 1;
                break;
            end
            if (tx_valid) begin
                check(tx_data == memf(16'(mptr + got)), "R3", tx_data, memf(16'(mptr + got)));
                got++;
                if (tx_last) break;
            end
            @(negedge clk);
            #1;
        end
        check(got == exp_len, "R3", got, exp_len);
        check(zlp == (exp_len == 0), "R5", zlp, exp_len == 0);
        @(negedge clk);
        in_ack = ack; in_timeout = !ack;
        @(negedge clk);
        in_ack = 1'b0; in_timeout = 1'b0;
        #1;
        if (ack) begin
            mptr += exp_len;
            mrem -= exp_len;
            if (exp_len < MPS) begin
                mact = 0;
                mdone = 1;
            end
        end
        check(done == mdone, "R6", done, mdone);
        check(reply_en == mact, "R4", reply_en, mact);
    endtask

    task automatic clear_done();
        wreg(3'd5, 8'h01);
        mdone = 0;
        check(done == 1'b0, "R7", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog act=0 exp=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(done == 0 && reply_en == 0 && tx_valid == 0 && tx_zlp == 0, "R1",
              {done, reply_en, tx_valid, tx_zlp}, 0);

        // R10: token while idle
        do_in(1);

        // R3/R6: 20 bytes -> 8, 8, 4
        arm(16'h0100, 20);
        do_in(1); do_in(1); do_in(1);
        check(done == 1'b1, "R6", done, 1);

        // R7: writing 0 keeps done, writing 1 clears
        wreg(3'd5, 8'h00);
        check(done == 1'b1, "R7", done, 1);
        clear_done();

        // R5: exact multiple -> trailing zero-length packet
        arm(16'h2000, 16);
        do_in(1); do_in(1); do_in(1);
        clear_done();

        // R5: size zero
        arm(16'h3000, 0);
        do_in(1);
        clear_done();

        // R4: timeout then resend the same packet
        arm(16'h12F8, 10);
        do_in(0); do_in(0); do_in(1); do_in(0); do_in(1);
        clear_done();

        // R8: enable without IN direction does not start
        wreg(3'd0, 8'h01);
        check(reply_en == 1'b0, "R8", reply_en, 0);
        do_in(1);
        check(done == 1'b0, "R8", done, 0);

        // R9: SETUP aborts mid-stage
        arm(16'h0400, 20);
        do_in(1);
        @(negedge clk);
        setup_rcvd = 1'b1;
        @(negedge clk);
        setup_rcvd = 1'b0;
        #1;
        mact = 0;
        check(reply_en == 1'b0, "R9", reply_en, 0);
        check(done == 1'b0, "R9", done, 0);
        do_in(1);

        // R2: restart after abort from a new window
        arm(16'hABCD, 5);
        do_in(1);
        check(done == 1'b1, "R6", done, 1);

        finish_run();
    end

endmodule